// File: doc/BRIEF.md
# ARINC 429 Receive Bit Decoder

This block turns the two digital level indications of an ARINC 429 line receiver into 32-bit words. One input says a high (ONE) level is present on the pair and the other says a low (ZERO) level is present. When neither is set, the line is at null. The block samples both lines on a sample strobe. It keeps short histories of the ONE, ZERO and null samples and treats a level as valid only after several agreeing samples. A bit is accepted when its level is followed by a qualified return to null.

A framer counts the accepted bits and shifts them into a word register. When the 32nd bit arrives, the framer raises a one-cycle end-of-word strobe together with the finished word. The eight label bits come first on the line, and the framer places them so that the label reads in its usual most-significant-first order.

A single null-run counter supports two timing rules. It enforces the minimum inter-word gap before a new word may begin. It also detects a null that lasts too long inside a word. A sample with both lines high, a level that flips without returning to null, and an over-long null all abort the partial word and raise an error strobe. A rate input chooses between sampling on every clock (high speed) and sampling once every `LS_DIV` clocks (low speed). With the default 1 MHz clock, both rates give the same number of samples per bit.

Top module: `a429_rx_decoder`

## Requirements
- R1: While `rst_n` is low, `eos` and `frame_err` are 0 and `word_out` is all zeros.
- R2: A ONE or ZERO level counts only after it is seen in `QUAL` (default 3) consecutive samples. A level lasting fewer samples produces no bit, no word and no error.
- R3: A bit is accepted when its qualified level is followed by `QUAL` consecutive null samples. After 32 accepted bits, `eos` is high for exactly one clock and `word_out` carries the word. `word_out` changes only in a cycle where `eos` is high.
- R4: For the line bits numbered 1 to 32 in arrival order, bit k with k ≥ 9 appears at `word_out[k-1]`. The first eight bits are reversed: bit k with k ≤ 8 appears at `word_out[8-k]`, so line bit 1 is `word_out[7]`.
- R5: After reset and after every completed or aborted word, the line must stay at null for `GAP_BITS*SPB` (default 40) consecutive samples before a word can start. Levels that arrive earlier are ignored without an error.
- R6: Outside the gap wait, a sample with both `line_one` and `line_zero` high discards the partial word and raises `frame_err` for one clock.
- R7: With between 1 and 31 bits collected, a null lasting more than `SPB` (default 10) samples discards the partial word and raises `frame_err` for one clock.
- R8: A qualified level followed by a qualified opposite level, with no qualified null between them, discards the partial word and raises `frame_err` for one clock.
- R9: With `rate_low` = 0 the lines are sampled on every clock. With `rate_low` = 1 they are sampled once every `LS_DIV` (default 8) clocks.
- R10: `eos` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (1 MHz in the intended use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_low | input | 1 | 0: sample every clock; 1: sample every LS_DIV clocks |
| line_one | input | 1 | Line receiver reports a high level |
| line_zero | input | 1 | Line receiver reports a low level |
| eos | output | 1 | One-cycle strobe: a complete 32-bit word is on word_out |
| word_out | output | 32 | Last completed word, label in usual order |
| frame_err | output | 1 | One-cycle strobe: a partial word was aborted |

## Verification
The hardest condition to reach from the ports is a word that starts while the gap wait is still running. Normal traffic always leaves a long enough null between words, so the stimulus has to end one good word with only a short null and then send a complete second word at once. That second word must produce neither a word nor an error, and the next properly spaced word must still decode. The three abort paths are reached in a similar way: the stimulus stops partway through a word and then drives a clash, an over-long null or a direct level flip. A word timed for the slow rate is also fed in while the block samples at the fast rate, which must end in aborts rather than a word.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

   localparam int unsigned WORD_BITS  = 32;
   localparam int unsigned LABEL_BITS = 8;
   localparam int unsigned CNT_W      = $clog2(WORD_BITS);

   typedef enum logic [1:0] {
      FR_GAP   = 2'd0,   // waiting for the minimum null gap
      FR_LEVEL = 2'd1,   // waiting for a qualified ONE or ZERO
      FR_NULL  = 2'd2    // level seen, waiting for return to null
   } fr_state_e;

endpackage

// File: rtl/a429_rx_rate_gen.sv
module a429_rx_rate_gen #(
   parameter int unsigned LS_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_low,
   output logic samp_tick
);

   localparam int unsigned DIV_W = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;

   generate
      if (LS_DIV <= 1) begin : g_nodiv
         assign samp_tick = 1'b1;
      end else begin : g_div
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(LS_DIV - 1);
         logic [DIV_W-1:0] div_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (!rate_low) begin
               div_cnt <= '0;
            end else if (div_cnt == DIV_LAST) begin
               div_cnt <= '0;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end

         assign samp_tick = rate_low ? (div_cnt == '0) : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/a429_rx_sampler.sv
module a429_rx_sampler #(
   parameter int unsigned QUAL     = 3,
   parameter int unsigned NRUN_MAX = 40,
   parameter int unsigned NW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          samp_tick,
   input  logic          line_one,
   input  logic          line_zero,
   output logic          upd,
   output logic          one_q,
   output logic          zero_q,
   output logic          null_q,
   output logic          clash,
   output logic [NW-1:0] nrun
);

   localparam logic [NW-1:0] NMAX_L = NW'(NRUN_MAX);

   logic [QUAL-1:0] hist_one;
   logic [QUAL-1:0] hist_zero;
   logic [QUAL-1:0] hist_null;
   logic            smp_null;

   assign smp_null = !line_one && !line_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_one  <= '0;
         hist_zero <= '0;
         hist_null <= '0;
         clash     <= 1'b0;
         nrun      <= '0;
         upd       <= 1'b0;
      end else begin
         upd <= samp_tick;
         if (samp_tick) begin
            hist_one  <= {hist_one[QUAL-2:0],  line_one};
            hist_zero <= {hist_zero[QUAL-2:0], line_zero};
            hist_null <= {hist_null[QUAL-2:0], smp_null};
            clash     <= line_one && line_zero;
            if (!smp_null) begin
               nrun <= '0;
            end else if (nrun != NMAX_L) begin
               nrun <= nrun + 1'b1;
            end
         end
      end
   end

   assign one_q  = &hist_one;
   assign zero_q = &hist_zero;
   assign null_q = &hist_null;

endmodule

// File: rtl/a429_rx_framer.sv
module a429_rx_framer
   import a429_rx_pkg::*;
#(
   parameter int unsigned SPB             = 10,
   parameter int unsigned GAP_SAMPLES     = 40,
   parameter int unsigned NW              = 6,
   parameter bit          LABEL_MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic                 one_q,
   input  logic                 zero_q,
   input  logic                 null_q,
   input  logic                 clash,
   input  logic [NW-1:0]        nrun,
   output logic                 eos,
   output logic [WORD_BITS-1:0] word_out,
   output logic                 frame_err
);

   localparam logic [NW-1:0]    GAP_L  = NW'(GAP_SAMPLES);
   localparam logic [NW-1:0]    SPB_L  = NW'(SPB);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(WORD_BITS - 1);

   fr_state_e              st;
   logic [CNT_W-1:0]       bit_cnt;
   logic                   cur_bit;
   logic [WORD_BITS-1:0]   shreg;
   logic [WORD_BITS-1:0]   shreg_nx;
   logic [WORD_BITS-1:0]   word_nx;

   assign shreg_nx = {cur_bit, shreg[WORD_BITS-1:1]};

   // Data bits keep their line position; the label field may be reversed
   assign word_nx[WORD_BITS-1:LABEL_BITS] = shreg_nx[WORD_BITS-1:LABEL_BITS];

   generate
      for (genvar gi = 0; gi < LABEL_BITS; gi++) begin : g_label
         if (LABEL_MSB_FIRST) begin : g_rev
            assign word_nx[gi] = shreg_nx[LABEL_BITS-1-gi];
         end else begin : g_fwd
            assign word_nx[gi] = shreg_nx[gi];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FR_GAP;
         bit_cnt   <= '0;
         cur_bit   <= 1'b0;
         shreg     <= '0;
         word_out  <= '0;
         eos       <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         eos       <= 1'b0;
         frame_err <= 1'b0;
         if (upd) begin
            if (clash && (st != FR_GAP)) begin
               st        <= FR_GAP;
               bit_cnt   <= '0;
               frame_err <= 1'b1;
            end else begin
               unique case (st)
                  FR_GAP: begin
                     if (nrun >= GAP_L) begin
                        st      <= FR_LEVEL;
                        bit_cnt <= '0;
                     end
                  end
                  FR_LEVEL: begin
                     if (one_q) begin
                        cur_bit <= 1'b1;
                        st      <= FR_NULL;
                     end else if (zero_q) begin
                        cur_bit <= 1'b0;
                        st      <= FR_NULL;
                     end else if ((bit_cnt != '0) && (nrun > SPB_L)) begin
                        st        <= FR_GAP;
                        bit_cnt   <= '0;
                        frame_err <= 1'b1;
                     end
                  end
                  FR_NULL: begin
                     if (null_q) begin
                        shreg <= shreg_nx;
                        if (bit_cnt == LAST_C) begin
                           word_out <= word_nx;
                           eos      <= 1'b1;
                           st       <= FR_GAP;
                           bit_cnt  <= '0;
                        end else begin
                           bit_cnt <= bit_cnt + 1'b1;
                           st      <= FR_LEVEL;
                        end
                     end else if (cur_bit ? zero_q : one_q) begin
                        st        <= FR_GAP;
                        bit_cnt   <= '0;
                        frame_err <= 1'b1;
                     end
                  end
                  default: begin
                     st      <= FR_GAP;
                     bit_cnt <= '0;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/a429_rx_decoder.sv
module a429_rx_decoder
   import a429_rx_pkg::*;
#(
   parameter int unsigned SPB             = 10,
   parameter int unsigned QUAL            = 3,
   parameter int unsigned GAP_BITS        = 4,
   parameter int unsigned LS_DIV          = 8,
   parameter bit          LABEL_MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rate_low,
   input  logic        line_one,
   input  logic        line_zero,
   output logic        eos,
   output logic [31:0] word_out,
   output logic        frame_err
);

   localparam int unsigned GAP_SAMPLES = GAP_BITS * SPB;
   localparam int unsigned NRUN_MAX    = (GAP_SAMPLES > SPB + 1) ? GAP_SAMPLES : SPB + 1;
   localparam int unsigned NW          = $clog2(NRUN_MAX + 1);

   generate
      if (QUAL < 2 || 2 * QUAL > SPB) begin : g_bad_qual
         $error("QUAL must be at least 2 and at most half of SPB");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("GAP_BITS must be at least 1");
      end
      if (LS_DIV < 1) begin : g_bad_div
         $error("LS_DIV must be at least 1");
      end
   endgenerate

   logic          samp_tick;
   logic          upd;
   logic          one_q;
   logic          zero_q;
   logic          null_q;
   logic          clash;
   logic [NW-1:0] nrun;

   a429_rx_rate_gen #(
      .LS_DIV (LS_DIV)
   ) u_rate (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_low  (rate_low),
      .samp_tick (samp_tick)
   );

   a429_rx_sampler #(
      .QUAL     (QUAL),
      .NRUN_MAX (NRUN_MAX),
      .NW       (NW)
   ) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_tick (samp_tick),
      .line_one  (line_one),
      .line_zero (line_zero),
      .upd       (upd),
      .one_q     (one_q),
      .zero_q    (zero_q),
      .null_q    (null_q),
      .clash     (clash),
      .nrun      (nrun)
   );

   a429_rx_framer #(
      .SPB             (SPB),
      .GAP_SAMPLES     (GAP_SAMPLES),
      .NW              (NW),
      .LABEL_MSB_FIRST (LABEL_MSB_FIRST)
   ) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (upd),
      .one_q     (one_q),
      .zero_q    (zero_q),
      .null_q    (null_q),
      .clash     (clash),
      .nrun      (nrun),
      .eos       (eos),
      .word_out  (word_out),
      .frame_err (frame_err)
   );

endmodule

// File: rtl/a429_rx_decoder_chk.sv
module a429_rx_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rate_low,
   input logic        samp_tick,
   input logic        eos,
   input logic        frame_err,
   input logic [31:0] word_out
);

   // R3: end-of-word strobe lasts a single cycle
   assert_eos_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eos |=> !eos);

   // R3: the word output moves only together with the strobe
   assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(word_out) |-> eos);

   // R6, R7, R8: an abort is reported for one cycle only
   assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R9: at the slow rate two sample strobes never come back to back
   assert_ls_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_low && samp_tick) |=> (!rate_low || !samp_tick));

   // R10: word strobe and error strobe are exclusive
   assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(eos && frame_err));

endmodule

bind a429_rx_decoder a429_rx_decoder_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rate_low  (rate_low),
   .samp_tick (samp_tick),
   .eos       (eos),
   .frame_err (frame_err),
   .word_out  (word_out)
);

// File: tb/tb_a429_rx_decoder.sv
module tb_a429_rx_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rate_low = 1'b0;
   logic        line_one = 1'b0;
   logic        line_zero = 1'b0;
   logic        eos;
   logic [31:0] word_out;
   logic        frame_err;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          eos_seen = 0;
   int          err_seen = 0;
   int          div = 1;
   logic [31:0] exp_q[$];
   logic [31:0] exp_w;

   always #10 clk = ~clk;

   a429_rx_decoder dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_low  (rate_low),
      .line_one  (line_one),
      .line_zero (line_zero),
      .eos       (eos),
      .word_out  (word_out),
      .frame_err (frame_err)
   );

   function automatic logic [7:0] rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = v[7-i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Monitor: pops the scoreboard on every end-of-word strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (eos) begin
            eos_seen++;
            chk("R10 strobes exclusive", {31'd0, frame_err}, 32'd0);
            if (exp_q.size() == 0) begin
               n_cmp++;
               n_bad++;
               $display("FAIL R3: actual word %h expected no word", word_out);
            end else begin
               exp_w = exp_q.pop_front();
               chk("R4 word content", word_out, exp_w);
            end
         end
         if (frame_err) err_seen++;
      end
   end

   task automatic hold(input logic o, input logic z, input int n);
      line_one  = o;
      line_zero = z;
      repeat (n * div) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] tx, input int n);
      for (int i = 0; i < n; i++) begin
         hold(tx[i], !tx[i], 5);
         hold(1'b0, 1'b0, 5);
      end
   endtask

   // Driver: queues the expected word, then sends it with a full gap
   task automatic send_word(input logic [31:0] tx, input int gap);
      exp_q.push_back({tx[31:8], rev8(tx[7:0])});
      send_bits(tx, 32);
      hold(1'b0, 1'b0, gap);
   endtask

   initial begin
      int e0;
      int w0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 eos", {31'd0, eos}, 32'd0);
      chk("R1 frame_err", {31'd0, frame_err}, 32'd0);
      chk("R1 word_out", word_out, 32'd0);
      rst_n = 1'b1;
      hold(1'b0, 1'b0, 60);

      // R3, R4: plain words at the fast rate
      send_word(32'hA5C3_1E81, 50);
      chk("R3 one word seen", eos_seen, 1);
      send_word(32'h0000_0001, 50);
      send_word(32'hFFFF_FFFF, 50);
      send_word(32'h1234_5678, 50);
      chk("R4 label order words", eos_seen, 4);

      // R5: second word starts before the gap has elapsed
      w0 = eos_seen; e0 = err_seen;
      send_word(32'h0F0F_00F0, 10);
      send_bits(32'hDEAD_BEEF, 32);
      hold(1'b0, 1'b0, 50);
      chk("R5 early word ignored", eos_seen, w0 + 1);
      chk("R5 no error on early word", err_seen, e0);
      send_word(32'h5555_AAAA, 50);
      chk("R5 word after gap", eos_seen, w0 + 2);

      // R2: short level pulse while armed
      e0 = err_seen; w0 = eos_seen;
      hold(1'b1, 1'b0, 2);
      hold(1'b0, 1'b0, 10);
      hold(1'b0, 1'b1, 2);
      hold(1'b0, 1'b0, 10);
      chk("R2 glitch no error", err_seen, e0);
      chk("R2 glitch no word", eos_seen, w0);
      send_word(32'h8000_0080, 50);

      // R6: clash in mid-word
      e0 = err_seen; w0 = eos_seen;
      send_bits(32'h0000_03FF, 10);
      hold(1'b1, 1'b1, 3);
      hold(1'b0, 1'b0, 50);
      chk("R6 clash error", err_seen, e0 + 1);
      chk("R6 clash no word", eos_seen, w0);
      send_word(32'hC001_CAFE, 50);

      // R7: null too long after 20 bits
      e0 = err_seen; w0 = eos_seen;
      send_bits(32'h000F_FFFF, 20);
      hold(1'b0, 1'b0, 50);
      chk("R7 timeout error", err_seen, e0 + 1);
      chk("R7 timeout no word", eos_seen, w0);
      send_word(32'h7E7E_1881, 50);

      // R8: level flips without null
      e0 = err_seen; w0 = eos_seen;
      send_bits(32'h0000_002A, 6);
      hold(1'b1, 1'b0, 5);
      hold(1'b0, 1'b1, 5);
      hold(1'b0, 1'b0, 50);
      chk("R8 flip error", err_seen, e0 + 1);
      chk("R8 flip no word", eos_seen, w0);
      send_word(32'h0BAD_F00D, 50);

      // R9: slow rate word
      rate_low = 1'b1;
      div = 8;
      hold(1'b0, 1'b0, 50);
      w0 = eos_seen;
      send_word(32'h3C3C_C3A1, 50);
      chk("R9 slow word", eos_seen, w0 + 1);

      // R9: slow-timed word while sampling fast is rejected
      rate_low = 1'b0;
      div = 1;
      hold(1'b0, 1'b0, 50);
      e0 = err_seen; w0 = eos_seen;
      div = 8;
      send_bits(32'h9999_6666, 32);
      div = 1;
      hold(1'b0, 1'b0, 50);
      chk("R9 fast sampling sees aborts", {31'd0, err_seen > e0}, 32'd1);
      chk("R9 fast sampling no word", eos_seen, w0);
      send_word(32'h2468_ACE1, 50);

      hold(1'b0, 1'b0, 20);
      chk("R3 scoreboard drained", exp_q.size(), 32'd0);
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

endmodule